// File: doc/BRIEF.md
# Fuse array burst read controller

This block sits between a 32-bit register bus and a one-time-programmable fuse macro holding 8192 bits. Software sets a timing word, then writes a start byte address, a byte count minus one and a go bit to the control word. The controller then walks the fuse macro one wide word at a time, copying up to 32 bytes into eight readable data words. Software polls a done bit before it reads the data.

Each fuse access has a programmable address setup time and strobe width, both counted in bus clocks. Every access returns two bytes at once, so an aligned pair of requested bytes costs one access. The timing fields are copied when a read starts, so later writes to the timing word cannot disturb a read that is already running. The program path of the macro is never driven.

Top module: `fuse_burst_reader`

## Requirements
- R1: After reset every register reads zero. Registers sit at byte offsets 0x0 (control), 0x4 (timing), 0x8 (status) and 0xC+4n (data word n, n=0..7). Control and timing read back the last value written.
- R2: A control write with bit 0 set starts a read. The start byte address is taken from bits 30:21 and the byte count minus one from bits 20:16.
- R3: Byte k of the burst (fuse byte start+k) lands in data word k/4 at bits 8*(k%4)+7 : 8*(k%4).
- R4: Before each strobe the fuse word address is held for exactly adj+1 cycles with the strobe low, and it stays unchanged while the strobe is high. Here adj is timing bits 23:20.
- R5: The strobe stays high for exactly stb+4 cycles, so one access lasts adj+5+stb cycles. Here stb is timing bits 19:16. A burst of N accesses sets done exactly N*(adj+5+stb) cycles after the control write edge.
- R6: Status bit 0 (done) reads 1 in the first cycle after the last access ends, with the strobe already low. Any control write clears it, and a write with bit 0 clear also stops the sequencer.
- R7: Writing the timing word while a read is running does not change that read's timing.
- R8: Control bits 15 and 1 are ignored: without bit 0 they start nothing. The program output to the macro is always 0.
- R9: Fuse word address = byte address >> 1 (9 bits). Lane 0 is fuse data bits 7:0 for even bytes and lane 1 is bits 15:8 for odd bytes. One access yields both lanes when both are requested. Byte addresses wrap from 1023 to 0.
- R10: Data bytes at positions beyond the requested count keep their previous values.
- R11: Status bit 1 and all status bits above bit 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fuse_addr | output | 9 | Fuse word address |
| fuse_strobe | output | 1 | Fuse read strobe |
| fuse_pgm | output | 1 | Fuse program pulse, held low |
| fuse_rdata | input | 16 | Fuse word data |

## Verification
The assertions check on every cycle that the fuse address holds steady through each strobe and for at least one cycle before it rises. They also check that a strobe lasts at least its minimum width unless a new control write cut it short, that done and the strobe are never high together, and that a control write clears done. Only the bench's scenarios can show the exact setup and strobe lengths for each timing setting, the total burst latency, the byte placement for unaligned and wrapping bursts, that timing writes during a read have no effect, and that bytes beyond the count are left alone.

// File: rtl/fuse_burst_reader.sv
module fuse_burst_reader #(
  parameter int BYTE_AW = 10,
  parameter int LEN_W   = 5,
  parameter int FUSE_AW = 9,
  parameter int FUSE_DW = 16,
  parameter int TIM_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [5:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [FUSE_AW-1:0] fuse_addr,
  output logic               fuse_strobe,
  output logic               fuse_pgm,
  input  logic [FUSE_DW-1:0] fuse_rdata
);
  localparam int NBYTES = 1 << LEN_W;
  localparam int NDW    = NBYTES / 4;
  localparam int DWI    = $clog2(NDW);
  localparam int LANES  = FUSE_DW / 8;
  localparam int LSB    = $clog2(LANES);
  localparam int KW     = LEN_W + 1;
  localparam int CW     = TIM_W + 3;
  localparam int A_LSB  = 21;
  localparam int L_LSB  = 16;
  localparam int ADJ_LSB = 20;
  localparam int STB_LSB = 16;

  logic [31:0]        ctrl_q, cfg_q;
  logic               done_q, busy_q;
  logic [BYTE_AW-1:0] start_q;
  logic [LEN_W-1:0]   len_q;
  logic [TIM_W-1:0]   adj_q, stb_q;
  logic [CW-1:0]      cnt_q;
  logic [KW-1:0]      k_q;
  logic [7:0]         dat_q [NBYTES];

  wire wr_ctrl = bus_wr && bus_addr[5:2] == 4'd0;
  wire wr_cfg  = bus_wr && bus_addr[5:2] == 4'd1;

  wire [BYTE_AW-1:0] cur_b   = start_q + BYTE_AW'(k_q);
  wire [LSB-1:0]     lane    = cur_b[LSB-1:0];
  wire [CW-1:0]      setup_c = CW'(adj_q) + CW'(1);
  wire [CW-1:0]      last_c  = CW'(adj_q) + CW'(stb_q) + CW'(4);
  wire               last_cyc = busy_q && cnt_q == last_c;
  wire [KW-1:0]      avail   = KW'(len_q) - k_q + KW'(1);
  wire [KW-1:0]      room    = KW'(LANES) - KW'(lane);
  wire [KW-1:0]      take    = (room < avail) ? room : avail;
  wire               fin     = (k_q + take) > KW'(len_q);

  assign fuse_addr   = FUSE_AW'(cur_b >> LSB);
  assign fuse_strobe = busy_q && cnt_q >= setup_c;
  assign fuse_pgm    = 1'b0;

  logic [KW-1:0] lane_idx [LANES];
  logic          lane_en  [LANES];
  always_comb
    for (int j = 0; j < LANES; j++) begin
      lane_idx[j] = k_q + KW'(j) - KW'(lane);
      lane_en[j]  = (j >= int'(lane)) && (lane_idx[j] <= KW'(len_q));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q  <= '0;
      cfg_q   <= '0;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= '0;
      len_q   <= '0;
      adj_q   <= '0;
      stb_q   <= '0;
      cnt_q   <= '0;
      k_q     <= '0;
      for (int i = 0; i < NBYTES; i++) dat_q[i] <= '0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata;
      if (wr_ctrl) begin
        ctrl_q  <= bus_wdata;
        done_q  <= 1'b0;
        busy_q  <= bus_wdata[0];
        start_q <= bus_wdata[A_LSB +: BYTE_AW];
        len_q   <= bus_wdata[L_LSB +: LEN_W];
        adj_q   <= cfg_q[ADJ_LSB +: TIM_W];
        stb_q   <= cfg_q[STB_LSB +: TIM_W];
        cnt_q   <= '0;
        k_q     <= '0;
      end else if (busy_q) begin
        if (last_cyc) begin
          for (int j = 0; j < LANES; j++)
            if (lane_en[j]) dat_q[lane_idx[j][LEN_W-1:0]] <= fuse_rdata[8*j +: 8];
          cnt_q <= '0;
          if (fin) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            k_q <= k_q + take;
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end

  logic [31:0] dword [NDW];
  for (genvar w = 0; w < NDW; w++) begin : g_word
    assign dword[w] = {dat_q[4*w+3], dat_q[4*w+2], dat_q[4*w+1], dat_q[4*w]};
  end

  wire [3:0] ridx = bus_addr[5:2] - 4'd3;
  always_comb
    case (bus_addr[5:2])
      4'd0:    bus_rdata = ctrl_q;
      4'd1:    bus_rdata = cfg_q;
      4'd2:    bus_rdata = {31'b0, done_q};
      default: bus_rdata = (bus_addr[5:2] >= 4'd3 && int'(ridx) < NDW) ? dword[ridx[DWI-1:0]] : 32'b0;
    endcase
endmodule

module fuse_burst_reader_chk #(
  parameter int FUSE_AW = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [5:0]         bus_addr,
  input logic [FUSE_AW-1:0] fuse_addr,
  input logic               fuse_strobe,
  input logic               done
);
  wire ctl_wr = bus_wr && bus_addr[5:2] == 4'd0;

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr));

  a_r4_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_strobe) |-> $stable(fuse_addr));

  a_r5_strobe_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fuse_strobe) && !$past(ctl_wr)) |-> ($past(fuse_strobe, 4) && $past(fuse_strobe, 3)));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fuse_strobe);
endmodule

bind fuse_burst_reader fuse_burst_reader_chk #(.FUSE_AW(FUSE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .fuse_addr(fuse_addr), .fuse_strobe(fuse_strobe), .done(done_q));

// File: tb/fuse_burst_reader_test.sv
module fuse_burst_reader_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [8:0]  fuse_addr;
  logic        fuse_strobe, fuse_pgm;
  logic [15:0] fuse_rdata = 0;

  always #10 clk = ~clk;

  fuse_burst_reader uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_addr(fuse_addr),
    .fuse_strobe(fuse_strobe), .fuse_pgm(fuse_pgm), .fuse_rdata(fuse_rdata));

  int nchk = 0, nbad = 0, cyc = 0, pgm_hits = 0;
  logic [15:0] mem [512];
  logic [7:0]  expd [32];

  function automatic logic [7:0] fbyte(int b);
    return 8'((b * 37 + 11) ^ (b >> 4));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (fuse_strobe) fuse_rdata <= mem[fuse_addr];
  end
  always @(negedge clk) if (fuse_pgm) pgm_hits++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic int n_access(int s, int l);
    int k = 0, n = 0;
    while (k <= l) begin
      int b = (s + k) & 1023;
      int t = 2 - (b & 1);
      if (t > l - k + 1) t = l - k + 1;
      k += t; n++;
    end
    return n;
  endfunction

  task automatic check_data(string req);
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      rd(6'(12 + 4 * w), v);
      check(req, v, {expd[4*w+3], expd[4*w+2], expd[4*w+1], expd[4*w]});
    end
  endtask

  task automatic do_read(int s, int l, int adj, int stb, bit chg);
    int nacc = n_access(s, l), tacc = adj + 5 + stb;
    int lo = 0, hi = 0, nh = 0, t0, el = -1;
    bit fin = 0;
    logic [31:0] v;
    wr(6'h04, (32'(adj) << 20) | (32'(stb) << 16) | ($urandom & 32'h8000_FFFF));
    for (int k = 0; k <= l; k++) expd[k] = fbyte((s + k) & 1023);
    wr(6'h00, (32'(s) << 21) | (32'(l) << 16) | 32'h1);
    t0 = cyc;
    for (int i = 0; i < 3000 && !fin; i++) begin
      if (chg && i == 3) wr(6'h04, 32'h00FF_0000 ^ ((32'(adj) << 20) | (32'(stb) << 16)));
      rd(6'h08, v);
      fin = v[0];
      if (fuse_strobe) begin
        if (lo > 0 && !chg) check("R4 setup cycles", lo, adj + 1);
        lo = 0; hi++;
      end else begin
        if (hi > 0) begin
          if (!chg) check("R5 strobe width", hi, stb + 4);
          nh++; hi = 0;
        end
        lo++;
      end
      if (fin) el = cyc - t0;
      else @(negedge clk);
    end
    check("R6 done set", {31'b0, fin}, 32'h1);
    check("R11 status upper bits", v & 32'hFFFF_FFFE, 32'h0);
    check(chg ? "R7 latency after timing rewrite" : "R5 burst latency", el, nacc * tacc);
    check("R9 access count", nh, nacc);
    check("R6 strobe low at done", lo, 1);
    rd(6'h00, v);
    check("R2 control readback", v, (32'(s) << 21) | (32'(l) << 16) | 32'h1);
    check_data("R3 R10 data placement");
  endtask

  initial begin
    #3000000;
    nbad++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hits;
    void'($urandom(77));
    for (int w = 0; w < 512; w++) mem[w] = {fbyte(2 * w + 1), fbyte(2 * w)};
    for (int k = 0; k < 32; k++) expd[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < 11; r++) begin
      rd(6'(4 * r), v);
      check("R1 reset value", v, 32'h0);
    end

    do_read(0, 31, 0, 0, 0);
    do_read(5, 31, 3, 7, 0);
    do_read(1020, 7, 1, 2, 0);
    do_read(1023, 0, 15, 15, 0);
    do_read(64, 2, 2, 1, 0);
    do_read(301, 20, 4, 3, 1);

    rd(6'h08, v);
    check("R6 done before clear", v, 32'h1);
    wr(6'h00, 32'h0);
    rd(6'h08, v);
    check("R6 done cleared by write", v, 32'h0);

    hits = 0;
    wr(6'h00, (32'd40 << 21) | (32'd31 << 16) | (32'h1 << 15) | 32'h2);
    for (int i = 0; i < 60; i++) begin
      if (fuse_strobe) hits++;
      @(negedge clk);
    end
    check("R8 no strobe without go bit", hits, 0);
    rd(6'h08, v);
    check("R8 status stays clear", v, 32'h0);
    check_data("R8 data untouched");

    do_read(200, 9, 1, 1, 0);
    wr(6'h00, (32'd500 << 21) | (32'd31 << 16) | 32'h1);
    repeat (10) @(negedge clk);
    wr(6'h00, 32'h0);
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      if (fuse_strobe) hits++;
      @(negedge clk);
    end
    check("R6 stop halts strobes", hits, 0);
    rd(6'h08, v);
    check("R6 no done after stop", v, 32'h0);

    for (int n = 0; n < 16; n++)
      do_read($urandom % 1024, $urandom % 32, $urandom % 16, $urandom % 16, n % 5 == 4);

    check("R8 program output low", pgm_hits, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule